// File: doc/BRIEF.md
# Rotating Current-Source Router with Trim Selection

This block drives the steering switches of six equal bias current sources in a bipolar temperature-sensing front end. Each source has a 2-bit select that sends it to the first transistor, to the second transistor, or to a diode-connected dummy load. The block has two modes, and only one is in effect at any time. In ratio mode it builds a 1:5 current ratio. In base-emitter mode it builds a trimmed bias current from the same sources.

In ratio mode one source is routed alone to the first transistor and the other five go to the second. The lone source changes on every modulator cycle, so mismatch between the sources averages out over a conversion. In base-emitter mode a coarse code switches a number of the first five sources onto the first transistor and parks the rest on the dummy load. The sixth source also goes to the first transistor, and a 4-bit fine code for its current DAC sets the fine step.

The modulator issues a cycle strobe once per cycle and a start-of-conversion pulse at the start of each conversion. Mode and trim requests are taken only on a strobe, and all selects are registered, so the routing never changes in the middle of a modulator cycle.

Top module: `dem_trim_sel`

## Requirements
- R1: After reset the block is in ratio mode with unit index 0: source 0 selects 01, sources 1 to 5 select 10 (sel_o = 12'hAA9), and dac_o is 0.
- R2: In ratio mode exactly one source carries the code 01 and every other source carries 10.
- R3: The unit index advances by one on each cycle strobe and wraps from 5 to 0. The new routing appears on the clock edge that samples the strobe.
- R4: Start of conversion resets the unit index to 0 on its edge. It takes priority over a strobe in the same cycle.
- R5: mode_req, coarse_i and fine_i are sampled only on a strobe edge. Changes to them between strobes leave sel_o and dac_o unchanged.
- R6: In base-emitter mode (mode_req = 1), a coarse code k routes sources 0 to k-1 with code 01 and parks sources k to 4 with code 00. Codes above 5 act as 5. Source 5 carries 01, and dac_o equals the latched fine code.
- R7: Source i's select sits at sel_o[2i+1:2i], with 00 for the dummy load, 01 for transistor Q1 and 10 for transistor Q2. The code 11 never appears.
- R8: The unit index keeps counting strobes while base-emitter mode is in effect. On return to ratio mode the unit source is the strobe count since the last reset or start of conversion, modulo 6.
- R9: dac_o is 0 whenever ratio mode is in effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_stb | input | 1 | One-cycle pulse per modulator cycle |
| soc | input | 1 | Start-of-conversion pulse |
| mode_req | input | 1 | Requested mode: 0 ratio, 1 base-emitter |
| coarse_i | input | 3 | Number of coarse sources to enable |
| fine_i | input | 4 | Fine DAC code |
| sel_o | output | 12 | Per-source 2-bit routing selects |
| dac_o | output | 4 | Fine DAC code to the sixth source |

## Verification
A wrong rotation index shows at sel_o on the edge of the very next strobe: the 01 code sits on the wrong source, or two sources carry it. A mode or trim value latched early shows on the edge where the request changes, before any strobe, as a change in sel_o or dac_o. A stale pointer kept across base-emitter mode or across a start of conversion shows on the first ratio-mode cycle afterwards. A reference model of the strobe count compares every output on every clock, so each of these faults is reported within one cycle of its effect.

// File: rtl/dem_trim_pkg.sv
package dem_trim_pkg;
  typedef enum logic {
    MODE_RATIO = 1'b0,
    MODE_BE    = 1'b1
  } dem_mode_e;

  localparam logic [1:0] SEL_DUMMY = 2'b00;
  localparam logic [1:0] SEL_Q1    = 2'b01;
  localparam logic [1:0] SEL_Q2    = 2'b10;
endpackage

// File: rtl/dem_rot_ptr.sv
module dem_rot_ptr #(
  parameter int N_SRC = 6,
  localparam int PW = $clog2(N_SRC)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cyc_stb,
  input  logic          soc,
  output logic [PW-1:0] ptr_nxt,
  output logic [PW-1:0] ptr_q
);
  localparam logic [PW-1:0] LAST = PW'(N_SRC - 1);

  always_comb begin
    if (soc)          ptr_nxt = '0;
    else if (cyc_stb) ptr_nxt = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
    else              ptr_nxt = ptr_q;
  end

  always_ff @(posedge clk) begin
    if (rst) ptr_q <= '0;
    else     ptr_q <= ptr_nxt;
  end

  AST_PTR_RANGE: assert property (@(posedge clk) disable iff (rst)
    ptr_q <= LAST); // R3
  AST_SOC_ZERO: assert property (@(posedge clk) disable iff (rst)
    soc |=> ptr_q == '0); // R4
endmodule

// File: rtl/dem_mode_latch.sv
module dem_mode_latch
  import dem_trim_pkg::*;
#(
  parameter int CRS_W  = 3,
  parameter int FINE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cyc_stb,
  input  logic              mode_req,
  input  logic [CRS_W-1:0]  coarse_i,
  input  logic [FINE_W-1:0] fine_i,
  output dem_mode_e         mode_nxt,
  output logic [CRS_W-1:0]  coarse_nxt,
  output logic [FINE_W-1:0] fine_nxt,
  output dem_mode_e         mode_q
);
  logic [CRS_W-1:0]  coarse_q;
  logic [FINE_W-1:0] fine_q;

  always_comb begin
    mode_nxt   = cyc_stb ? dem_mode_e'(mode_req) : mode_q;
    coarse_nxt = cyc_stb ? coarse_i : coarse_q;
    fine_nxt   = cyc_stb ? fine_i   : fine_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= MODE_RATIO;
      coarse_q <= '0;
      fine_q   <= '0;
    end else begin
      mode_q   <= mode_nxt;
      coarse_q <= coarse_nxt;
      fine_q   <= fine_nxt;
    end
  end

  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !cyc_stb |=> $stable(mode_q)); // R5
endmodule

// File: rtl/dem_route_dec.sv
module dem_route_dec
  import dem_trim_pkg::*;
#(
  parameter int N_SRC  = 6,
  parameter int CRS_W  = 3,
  parameter int FINE_W = 4,
  localparam int PW = $clog2(N_SRC)
) (
  input  dem_mode_e           mode,
  input  logic [PW-1:0]       ptr,
  input  logic [CRS_W-1:0]    coarse,
  input  logic [FINE_W-1:0]   fine,
  output logic [2*N_SRC-1:0]  sel,
  output logic [FINE_W-1:0]   dac
);
  localparam int N_CRS = N_SRC - 1;
  logic [CRS_W-1:0] crs_eff;

  assign crs_eff = (coarse > CRS_W'(N_CRS)) ? CRS_W'(N_CRS) : coarse;
  assign dac     = (mode == MODE_BE) ? fine : '0;

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    always_comb begin
      if (mode == MODE_RATIO) begin
        sel[2*i +: 2] = (ptr == PW'(i)) ? SEL_Q1 : SEL_Q2;
      end else if (i == N_CRS) begin
        sel[2*i +: 2] = SEL_Q1;
      end else begin
        sel[2*i +: 2] = (CRS_W'(i) < crs_eff) ? SEL_Q1 : SEL_DUMMY;
      end
    end
  end
endmodule

// File: rtl/dem_trim_sel.sv
module dem_trim_sel
  import dem_trim_pkg::*;
#(
  parameter int N_SRC  = 6,
  parameter int FINE_W = 4,
  localparam int CRS_W = $clog2(N_SRC),
  localparam int PW    = $clog2(N_SRC)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cyc_stb,
  input  logic                soc,
  input  logic                mode_req,
  input  logic [CRS_W-1:0]    coarse_i,
  input  logic [FINE_W-1:0]   fine_i,
  output logic [2*N_SRC-1:0]  sel_o,
  output logic [FINE_W-1:0]   dac_o
);
  logic [PW-1:0]       ptr_nxt, ptr_q;
  dem_mode_e           mode_nxt, mode_q;
  logic [CRS_W-1:0]    coarse_nxt;
  logic [FINE_W-1:0]   fine_nxt;
  logic [2*N_SRC-1:0]  sel_nxt;
  logic [FINE_W-1:0]   dac_nxt;

  dem_rot_ptr #(.N_SRC(N_SRC)) ptr_i (
    .clk(clk), .rst(rst), .cyc_stb(cyc_stb), .soc(soc),
    .ptr_nxt(ptr_nxt), .ptr_q(ptr_q)
  );

  dem_mode_latch #(.CRS_W(CRS_W), .FINE_W(FINE_W)) latch_i (
    .clk(clk), .rst(rst), .cyc_stb(cyc_stb), .mode_req(mode_req),
    .coarse_i(coarse_i), .fine_i(fine_i),
    .mode_nxt(mode_nxt), .coarse_nxt(coarse_nxt), .fine_nxt(fine_nxt),
    .mode_q(mode_q)
  );

  dem_route_dec #(.N_SRC(N_SRC), .CRS_W(CRS_W), .FINE_W(FINE_W)) dec_i (
    .mode(mode_nxt), .ptr(ptr_nxt), .coarse(coarse_nxt), .fine(fine_nxt),
    .sel(sel_nxt), .dac(dac_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N_SRC; i++) sel_o[2*i +: 2] <= (i == 0) ? SEL_Q1 : SEL_Q2;
      dac_o <= '0;
    end else begin
      sel_o <= sel_nxt;
      dac_o <= dac_nxt;
    end
  end

  logic [N_SRC-1:0] q1_vec, bad_vec;
  for (genvar i = 0; i < N_SRC; i++) begin : g_chk
    assign q1_vec[i]  = (sel_o[2*i +: 2] == SEL_Q1);
    assign bad_vec[i] = (sel_o[2*i +: 2] == 2'b11);
  end

  AST_ONE_UNIT: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_RATIO) |-> $countones(q1_vec) == 1); // R2
  AST_ROTATE: assert property (@(posedge clk) disable iff (rst)
    (cyc_stb && !soc && mode_q == MODE_RATIO && mode_req == 1'b0) |=> sel_o != $past(sel_o)); // R3
  AST_NO_ILLEGAL: assert property (@(posedge clk) disable iff (rst)
    bad_vec == '0); // R7
  AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!cyc_stb && !soc) |=> ($stable(sel_o) && $stable(dac_o))); // R5
  AST_DAC_IDLE: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_RATIO) |-> dac_o == '0); // R9
endmodule

// File: tb/dem_trim_sel_tb.sv
module dem_trim_sel_tb_top;
  localparam int NS = 6;
  localparam int FW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cyc_stb = 1'b0, soc = 1'b0, mode_req = 1'b0;
  logic [2:0] coarse_i = '0;
  logic [FW-1:0] fine_i = '0;
  logic [2*NS-1:0] sel_o;
  logic [FW-1:0] dac_o;

  int errors = 0, checks = 0;
  bit done = 0;
  string tag = "R1";

  int m_ptr = 0, m_mode = 0, m_crs = 0, m_fine = 0;

  always #10 clk = ~clk;

  dem_trim_sel #(.N_SRC(NS), .FINE_W(FW)) dut_i (
    .clk(clk), .rst(rst), .cyc_stb(cyc_stb), .soc(soc), .mode_req(mode_req),
    .coarse_i(coarse_i), .fine_i(fine_i), .sel_o(sel_o), .dac_o(dac_o)
  );

  always @(posedge clk) begin
    if (rst) begin
      m_ptr = 0; m_mode = 0; m_crs = 0; m_fine = 0;
    end else begin
      if (cyc_stb) begin
        m_mode = mode_req; m_crs = coarse_i; m_fine = fine_i;
      end
      if (soc) m_ptr = 0;
      else if (cyc_stb) m_ptr = (m_ptr + 1) % NS;
    end
  end

  function automatic logic [2*NS-1:0] exp_sel();
    logic [2*NS-1:0] v;
    int k;
    k = (m_crs > NS - 1) ? NS - 1 : m_crs;
    for (int i = 0; i < NS; i++) begin
      if (m_mode == 0) v[2*i +: 2] = (i == m_ptr) ? 2'b01 : 2'b10;
      else if (i == NS - 1) v[2*i +: 2] = 2'b01;
      else v[2*i +: 2] = (i < k) ? 2'b01 : 2'b00;
    end
    return v;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    int ones, bad;
    ones = 0; bad = 0;
    for (int i = 0; i < NS; i++) begin
      if (sel_o[2*i +: 2] == 2'b01) ones++;
      if (sel_o[2*i +: 2] == 2'b11) bad++;
    end
    check(tag, 32'(sel_o), 32'(exp_sel()));
    check("R7", 32'(bad), 0);
    if (m_mode == 0) begin
      check("R2", 32'(ones), 1);
      check("R9", 32'(dac_o), 0);
    end else begin
      check("R6", 32'(dac_o), 32'(m_fine));
    end
  endtask

  task automatic step(input logic stb, input logic s, input logic md,
                      input logic [2:0] c, input logic [FW-1:0] f);
    cyc_stb = stb; soc = s; mode_req = md; coarse_i = c; fine_i = f;
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1", 32'(sel_o), 32'h0AA9);
    check("R1", 32'(dac_o), 0);
    @(negedge clk);
    compare_all();

    tag = "R3";
    for (int n = 0; n < 14; n++) begin
      step(1, 0, 0, 0, 0);
      step(0, 0, 0, 0, 0);
      step(0, 0, 0, 0, 0);
    end

    tag = "R5";
    step(0, 0, 1, 3'd4, 4'hF);
    step(0, 0, 1, 3'd2, 4'h7);
    step(0, 0, 0, 3'd5, 4'h3);

    tag = "R4";
    step(1, 0, 0, 0, 0);
    step(0, 1, 0, 0, 0);
    check("R4", 32'(sel_o[1:0]), 32'h1);
    step(1, 0, 0, 0, 0);
    step(1, 1, 0, 0, 0);
    check("R4", 32'(sel_o[1:0]), 32'h1);

    tag = "R6";
    for (int c = 0; c < 8; c++) begin
      step(1, 0, 1, 3'(c), 4'(c * 2 + 1));
      step(0, 0, 1, 3'(7 - c), 4'(15 - c));
    end
    step(1, 0, 1, 3'd7, 4'hA);
    check("R6", 32'(sel_o), 32'h0555);
    check("R6", 32'(dac_o), 32'hA);
    step(1, 0, 1, 3'd0, 4'h0);
    check("R6", 32'(sel_o), 32'h0400);

    tag = "R5";
    step(0, 0, 0, 3'd3, 4'h9);
    step(0, 0, 0, 3'd1, 4'h2);

    tag = "R8";
    step(1, 0, 0, 0, 0);
    for (int n = 0; n < 7; n++) step(1, 0, 0, 0, 0);
    step(1, 1, 1, 3'd2, 4'h5);
    step(1, 0, 0, 0, 0);
    check("R8", 32'(sel_o[3:2]), 32'h1);
    step(0, 0, 0, 0, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule